// File: doc/BRIEF.md
# FM Deviation and Auto-Load Controller

This block builds the per-clock phase increment of a numerically controlled oscillator. It holds a 32-bit carrier frequency word and a frequency-modulation term. The FM term is a 16-bit unsigned magnitude with a sign flag and a two-bit deviation code. The increment is the carrier plus or minus the magnitude shifted left by four bits per step of the deviation code, taken modulo 2^32. The increment is driven from one register, so any update shows up as a single change of the whole word.

New FM data is captured in one of two ways. In manual mode, the controller captures on the cycle after it sees a falling edge on the FM strobe. In the automatic modes, it samples the FM inputs every 4, 8 or 16 clocks. One clock before each automatic sample, it drops an active-low sync output for one cycle so that external logic knows when to present data. The carrier word has its own strobe. A joint-load input makes every FM capture take the carrier input in the same clock edge, so both halves of a frequency hop change together.

Top module: `fm_dev_ctrl`

## Requirements
- R1: While `rst_i` is high, and on the first clock after it, `incr_o` is zero and `fm_sync_n_o` is high.
- R2: The FM magnitude is shifted left by 0, 4, 8 or 12 bits for `dev_sel_i` = 0, 1, 2 or 3. The deviation code is captured together with the magnitude.
- R3: With the captured sign `fm_neg_i` = 1, the scaled magnitude is subtracted from the carrier. With the sign at 0, it is added. Both results wrap modulo 2^32.
- R4: Take `rate_sel_i` = 0. If the edge k samples `fm_ld_i` low and the edge before it sampled it high, the FM inputs are captured at edge k+1 and `incr_o` shows the result after edge k+2.
- R5: A falling edge of `car_ld_i` detected at edge k captures `carrier_i` at edge k+1. `incr_o` shows the new carrier, with the held FM term applied, after edge k+2.
- R6: If `joint_ld_i` is high when the FM inputs are captured, `carrier_i` is captured at the same edge. If it is low, the held carrier is kept, whatever `carrier_i` carries.
- R7: `rate_sel_i` = 1, 2 and 3 select automatic periods P of 4, 8 and 16. Let the first edge that sees the new code be edge e. Then `fm_sync_n_o` is low for exactly one cycle after edges e+P, e+2P and so on, and is high otherwise.
- R8: In an automatic mode, the FM inputs are captured at the edge that follows a low `fm_sync_n_o`. `incr_o` shows the result one edge later.
- R9: In an automatic mode, a high `fm_ld_i` at the edge where the sync pulse would start suppresses both the pulse and the capture.
- R10: With `rate_sel_i` = 0, `fm_sync_n_o` stays high.
- R11: `incr_o` changes only two edges after a capture of FM or carrier data. Changes on `carrier_i` or the FM inputs without a capture leave it unchanged.
- R12: The period counter restarts from zero on any change of `rate_sel_i`, so the first pulse after a change comes P edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| carrier_i | input | 32 | Carrier frequency word to capture |
| car_ld_i | input | 1 | Carrier strobe, falling edge requests a load |
| fm_word_i | input | 16 | Unsigned FM magnitude |
| fm_neg_i | input | 1 | FM sign, 1 subtracts |
| dev_sel_i | input | 2 | Deviation code, shift of 4 bits per step |
| fm_ld_i | input | 1 | FM strobe in manual mode, load blocker in automatic modes |
| joint_ld_i | input | 1 | Capture the carrier together with each FM capture |
| rate_sel_i | input | 2 | 0 manual, 1/2/3 automatic every 4/8/16 clocks |
| fm_sync_n_o | output | 1 | Active-low one-cycle pulse before each automatic sample |
| incr_o | output | 32 | Registered phase increment |

## Verification
A strobe fall driven between edges n and n+1 is detected at edge n+1 and captured at n+2, and `incr_o` is compared after edge n+3. A rate code driven at the same point sees its first sync pulse after edge n+1+P, its capture at n+2+P and its increment after n+3+P. The cycle just before that pulse and the cycle just after it are also checked, to pin down the period and the one-cycle width. Each stimulus task pushes its expected values into a queue, tagged with the exact due cycle. A monitor compares them on the falling edge of that cycle only. Held-value checks, which cover a blocked load, a carrier change without joint load and idle inputs, are due after the point where a wrong capture would already have reached the output.

// File: rtl/fm_dev_pkg.sv
package fm_dev_pkg;

    localparam int FM_W         = 16;
    localparam int FRQ_W        = 32;
    localparam int SEL_W        = 2;
    localparam int SHIFT_STEP   = 4;
    localparam int MIN_PER_LOG2 = 2;
    localparam int CNT_W        = MIN_PER_LOG2 + (1 << SEL_W) - 2;
    localparam int N_STROBE     = 2;

    typedef logic [FRQ_W-1:0] frq_t;
    typedef logic [FM_W-1:0]  fmw_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        RATE_MANUAL = 2'd0,
        RATE_P4     = 2'd1,
        RATE_P8     = 2'd2,
        RATE_P16    = 2'd3
    } rate_e;

    typedef struct packed {
        logic neg;
        sel_t dev;
        fmw_t word;
    } fm_item_t;

    localparam int STB_CAR = 0;
    localparam int STB_FM  = 1;

    function automatic cnt_t last_count(input sel_t rate);
        int per_log2;
        if (rate == RATE_MANUAL) return '0;
        per_log2 = MIN_PER_LOG2 + int'(rate) - 1;
        return cnt_t'((1 << per_log2) - 1);
    endfunction

    function automatic frq_t scale_fm(input fm_item_t it);
        frq_t wide;
        wide = frq_t'(it.word);
        return wide << (SHIFT_STEP * int'(it.dev));
    endfunction

    function automatic frq_t apply_fm(input frq_t car, input fm_item_t it);
        frq_t delta;
        delta = scale_fm(it);
        return it.neg ? (car - delta) : (car + delta);
    endfunction

endpackage

// File: rtl/fm_fall_arm.sv
module fm_fall_arm (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strobe_i,
    input  logic enable_i,
    output logic arm_o
);
    logic prev_q;
    logic arm_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            prev_q <= strobe_i;
            arm_q  <= enable_i & prev_q & ~strobe_i;
        end
    end

    assign arm_o = arm_q;
endmodule

// File: rtl/fm_rate_timer.sv
module fm_rate_timer
    import fm_dev_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  sel_t rate_i,
    input  logic block_i,
    output logic sync_n_o
);
    sel_t rate_q;
    cnt_t cnt_q;
    logic sync_n_q;
    logic auto_run;
    logic at_last;

    assign auto_run = (rate_i != RATE_MANUAL) && (rate_i == rate_q);
    assign at_last  = (cnt_q == last_count(rate_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rate_q   <= RATE_MANUAL;
            cnt_q    <= '0;
            sync_n_q <= 1'b1;
        end else begin
            rate_q <= rate_i;
            if (!auto_run || at_last) cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
            sync_n_q <= ~(auto_run && at_last && !block_i);
        end
    end

    assign sync_n_o = sync_n_q;
endmodule

// File: rtl/fm_incr_core.sv
module fm_incr_core
    import fm_dev_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     fm_take_i,
    input  logic     car_take_i,
    input  logic     joint_i,
    input  frq_t     carrier_i,
    input  fm_item_t item_i,
    output frq_t     incr_o
);
    frq_t     car_q;
    fm_item_t item_q;
    frq_t     incr_q;
    logic     car_we;

    assign car_we = car_take_i | (fm_take_i & joint_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            car_q  <= '0;
            item_q <= '0;
            incr_q <= '0;
        end else begin
            if (car_we)    car_q  <= carrier_i;
            if (fm_take_i) item_q <= item_i;
            incr_q <= apply_fm(car_q, item_q);
        end
    end

    assign incr_o = incr_q;
endmodule

// File: rtl/fm_dev_ctrl.sv
module fm_dev_ctrl
    import fm_dev_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [31:0] carrier_i,
    input  logic        car_ld_i,
    input  logic [15:0] fm_word_i,
    input  logic        fm_neg_i,
    input  logic [1:0]  dev_sel_i,
    input  logic        fm_ld_i,
    input  logic        joint_ld_i,
    input  logic [1:0]  rate_sel_i,
    output logic        fm_sync_n_o,
    output logic [31:0] incr_o
);
    logic [N_STROBE-1:0] stb_in;
    logic [N_STROBE-1:0] stb_en;
    logic [N_STROBE-1:0] stb_arm;
    logic     sync_n;
    logic     fm_take;
    logic     car_take;
    fm_item_t item;

    assign stb_in[STB_CAR] = car_ld_i;
    assign stb_en[STB_CAR] = 1'b1;
    assign stb_in[STB_FM]  = fm_ld_i;
    assign stb_en[STB_FM]  = (rate_sel_i == RATE_MANUAL);

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        fm_fall_arm u_arm (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .strobe_i (stb_in[g]),
            .enable_i (stb_en[g]),
            .arm_o    (stb_arm[g])
        );
    end

    fm_rate_timer u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rate_i   (rate_sel_i),
        .block_i  (fm_ld_i),
        .sync_n_o (sync_n)
    );

    assign fm_take  = stb_arm[STB_FM] | ~sync_n;
    assign car_take = stb_arm[STB_CAR];

    assign item.neg  = fm_neg_i;
    assign item.dev  = dev_sel_i;
    assign item.word = fm_word_i;

    fm_incr_core u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fm_take_i  (fm_take),
        .car_take_i (car_take),
        .joint_i    (joint_ld_i),
        .carrier_i  (carrier_i),
        .item_i     (item),
        .incr_o     (incr_o)
    );

    assign fm_sync_n_o = sync_n;
endmodule

// File: rtl/fm_dev_ctrl_chk.sv
module fm_dev_ctrl_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        fm_ld_i,
    input logic [1:0]  rate_sel_i,
    input logic        fm_sync_n_o,
    input logic [31:0] incr_o,
    input logic        fm_take,
    input logic        car_take
);
    AST_RESET_STATE: assert property (@(posedge clk_i) rst_i |=> (fm_sync_n_o && incr_o == 32'd0)); // R1
    AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i) !fm_sync_n_o |=> fm_sync_n_o); // R7
    AST_SYNC_BLOCKED: assert property (@(posedge clk_i) disable iff (rst_i) fm_ld_i |=> fm_sync_n_o); // R9
    AST_SYNC_QUIET_MANUAL: assert property (@(posedge clk_i) disable iff (rst_i) (rate_sel_i == 2'd0) |=> fm_sync_n_o); // R10
    AST_RATE_RESTART: assert property (@(posedge clk_i) disable iff (rst_i) (rate_sel_i != $past(rate_sel_i)) |=> fm_sync_n_o); // R12
    AST_INCR_HELD: assert property (@(posedge clk_i) disable iff (rst_i) !$past(fm_take | car_take, 2) |-> $stable(incr_o)); // R11
endmodule

bind fm_dev_ctrl fm_dev_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .fm_ld_i     (fm_ld_i),
    .rate_sel_i  (rate_sel_i),
    .fm_sync_n_o (fm_sync_n_o),
    .incr_o      (incr_o),
    .fm_take     (fm_take),
    .car_take    (car_take)
);

// File: tb/sim_fm_dev_ctrl.sv
`timescale 1ns/1ps
module sim_fm_dev_ctrl;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic [31:0] carrier_i = '0;
    logic        car_ld_i = 1'b0;
    logic [15:0] fm_word_i = '0;
    logic        fm_neg_i = 1'b0;
    logic [1:0]  dev_sel_i = '0;
    logic        fm_ld_i = 1'b0;
    logic        joint_ld_i = 1'b0;
    logic [1:0]  rate_sel_i = '0;
    logic        fm_sync_n_o;
    logic [31:0] incr_o;

    always #2.5 clk = ~clk;

    fm_dev_ctrl u0 (
        .clk_i(clk), .rst_i(rst_i), .carrier_i(carrier_i), .car_ld_i(car_ld_i),
        .fm_word_i(fm_word_i), .fm_neg_i(fm_neg_i), .dev_sel_i(dev_sel_i),
        .fm_ld_i(fm_ld_i), .joint_ld_i(joint_ld_i), .rate_sel_i(rate_sel_i),
        .fm_sync_n_o(fm_sync_n_o), .incr_o(incr_o)
    );

    typedef struct {
        int          due;
        bit          is_sync;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] car_m = '0;
    logic [15:0] w_m = '0;
    logic        n_m = 1'b0;
    logic [1:0]  d_m = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model_incr();
        logic [31:0] s;
        s = {16'd0, w_m} * (32'd1 << (4 * d_m));
        return n_m ? car_m - s : car_m + s;
    endfunction

    task automatic push(input int due, input bit s, input logic [31:0] v, input string tag);
        exp_t e;
        e.due = due; e.is_sync = s; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                logic [31:0] act;
                act = q[i].is_sync ? {31'd0, fm_sync_n_o} : incr_o;
                checks++;
                if (act !== q[i].val) begin
                    errors++;
                    $display("FAIL %s cycle %0d actual %h expected %h", q[i].tag, cyc, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic load_car(input logic [31:0] c, input string tag);
        @(negedge clk);
        carrier_i = c; car_ld_i = 1'b1;
        @(negedge clk);
        car_ld_i = 1'b0;
        car_m = c;
        push(cyc + 3, 0, model_incr(), tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic load_fm(input logic [15:0] w, input logic n, input logic [1:0] d,
                           input logic joint, input logic [31:0] cnew, input string tag);
        @(negedge clk);
        fm_word_i = w; fm_neg_i = n; dev_sel_i = d;
        joint_ld_i = joint; carrier_i = cnew; fm_ld_i = 1'b1;
        @(negedge clk);
        fm_ld_i = 1'b0;
        w_m = w; n_m = n; d_m = d;
        if (joint) car_m = cnew;
        push(cyc + 2, 1, 32'd1, "R10 sync high in manual mode");
        push(cyc + 3, 0, model_incr(), tag);
        repeat (3) @(negedge clk);
        joint_ld_i = 1'b0;
    endtask

    task automatic auto_run(input logic [1:0] rate, input logic [15:0] w, input logic n,
                            input logic [1:0] d, input string tag);
        int n0, per;
        @(negedge clk);
        fm_word_i = w; fm_neg_i = n; dev_sel_i = d; rate_sel_i = rate;
        n0 = cyc;
        per = 2 ** (int'(rate) + 1);
        w_m = w; n_m = n; d_m = d;
        push(n0 + per,     1, 32'd1, {tag, " R7 R12 no pulse before period"});
        push(n0 + 1 + per, 1, 32'd0, {tag, " R7 pulse at period"});
        push(n0 + 2 + per, 1, 32'd1, {tag, " R7 pulse one cycle"});
        push(n0 + 3 + per, 0, model_incr(), {tag, " R8 auto capture"});
        repeat (per + 4) @(negedge clk);
        rate_sel_i = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        push(cyc + 1, 0, 32'd0, "R1 reset increment");
        push(cyc + 1, 1, 32'd1, "R1 reset sync");
        rst_i = 1'b0;
        repeat (2) @(negedge clk);

        load_car(32'h1000_0000, "R5 carrier load");
        load_fm(16'h1234, 1'b0, 2'd0, 1'b0, carrier_i, "R4 R2 R3 add shift 0");
        load_fm(16'h1234, 1'b1, 2'd1, 1'b0, carrier_i, "R2 R3 subtract shift 4");
        load_fm(16'h00AB, 1'b0, 2'd2, 1'b0, carrier_i, "R2 add shift 8");
        load_fm(16'hFFFF, 1'b0, 2'd3, 1'b0, carrier_i, "R2 add shift 12");
        load_car(32'hFFFF_FFF0, "R5 R3 carrier with held FM term");
        load_fm(16'h0020, 1'b0, 2'd0, 1'b0, carrier_i, "R3 add wraps");
        load_car(32'h0000_0010, "R5 new carrier");
        load_fm(16'h0002, 1'b1, 2'd1, 1'b0, carrier_i, "R3 subtract wraps");
        load_fm(16'h0100, 1'b0, 2'd1, 1'b1, 32'h2222_0000, "R6 joint load takes carrier");
        load_fm(16'h0001, 1'b0, 2'd0, 1'b0, 32'h5555_0000, "R6 no joint keeps carrier");

        @(negedge clk);
        carrier_i = 32'hDEAD_BEEF; fm_word_i = 16'h7777; dev_sel_i = 2'd3; fm_neg_i = 1'b1;
        push(cyc + 4, 0, model_incr(), "R11 unchanged without capture");
        repeat (5) @(negedge clk);

        auto_run(2'd1, 16'h0010, 1'b0, 2'd0, "rate 4");
        auto_run(2'd2, 16'h0003, 1'b1, 2'd2, "rate 8");
        auto_run(2'd3, 16'h0F00, 1'b0, 2'd1, "rate 16");

        @(negedge clk);
        rate_sel_i = 2'd3;
        repeat (6) @(negedge clk);
        auto_run(2'd1, 16'h0042, 1'b0, 2'd0, "restart");

        @(negedge clk);
        fm_ld_i = 1'b1;
        @(negedge clk);
        fm_word_i = 16'h0999; fm_neg_i = 1'b0; dev_sel_i = 2'd0; rate_sel_i = 2'd1;
        push(cyc + 5, 1, 32'd1, "R9 blocked pulse");
        push(cyc + 7, 0, model_incr(), "R9 blocked capture");
        repeat (8) @(negedge clk);
        rate_sel_i = 2'd0;
        @(negedge clk);
        fm_ld_i = 1'b0;
        w_m = 16'h0999; n_m = 1'b0; d_m = 2'd0;
        push(cyc + 3, 0, model_incr(), "R4 manual load after auto");
        repeat (5) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule